// File: doc/BRIEF.md
# Audio Receive Word FIFO

This block is a small first-in first-out store. It sits between a serial audio receiver, which signals each finished word with a one-cycle strobe, and a processor read port. Each strobe writes the incoming word into the slot at the write pointer. Each read strobe returns the slot at the read pointer and then advances that pointer. Both pointers wrap modulo the depth.

Full and empty are not taken from an extra pointer bit. When the two pointers are equal, a two-state direction machine tells the cases apart. The machine records whether the last access that changed occupancy was a write or a read.

- State `DIR_READ`: the last such access was a read. This is the reset state.
- State `DIR_WRITE`: the last such access was a write.
- A push that is accepted, with no pop in the same cycle, moves the machine to `DIR_WRITE`.
- A pop with no accepted push moves it to `DIR_READ`.
- Any other combination holds the state.

A word that arrives while the store is full is dropped. The write pointer holds, and a sticky overrun bit is set. Software clears that bit with a write-one strobe. The receive interrupt request is a level: it is high while the store holds data and the enable is set. Reading an empty store is not blocked. The read returns whatever the slot holds and the pointer moves on.

Top module: `rxf_audio_rx`

## Requirements
- R1: Each accepted `word_valid` strobe stores `word_data` at the write pointer, and the write pointer advances by one modulo DEPTH. Words read out in the order they arrived.
- R2: While `rd_pop` is high, `rd_data` shows the slot at the read pointer in that same cycle. At the clock edge the read pointer advances by one modulo DEPTH.
- R3: `fifo_full` is high when the pointers are equal and the last occupancy-changing access was a write. `fifo_empty` is high when they are equal and it was a read. The two are never high together.
- R4: A `word_valid` that arrives while `fifo_full` is high is discarded and the write pointer holds. This applies even with `rd_pop` in the same cycle, because fullness is judged before the edge.
- R5: Such a discarded word sets `ovr_flag` one cycle later.
- R6: `ovr_flag` stays set until an `ovr_clr` strobe clears it. If an overrun and `ovr_clr` occur in the same cycle, the flag is set.
- R7: `rx_irq` equals `irq_en` AND NOT `fifo_empty`.
- R8: An overrun word never raises `rx_irq`. An overrun cycle without a pop leaves `rx_irq` unchanged.
- R9: `rd_pop` on an empty store is not blocked. It returns the stale slot at the read pointer, advances the read pointer, and does not touch `ovr_flag`.
- R10: A push and a pop in the same cycle on a store that is not full both take effect, and `fifo_full`/`fifo_empty` keep their values.
- R11: After reset both pointers are zero, the direction is `DIR_READ`, `fifo_empty` is 1, and `fifo_full`, `ovr_flag` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_valid | input | 1 | Strobe: a received word is complete |
| word_data | input | DATA_W | Received word |
| rd_pop | input | 1 | Read strobe from the data register |
| rd_data | output | DATA_W | Slot at the read pointer |
| irq_en | input | 1 | Receive interrupt enable |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun bit |
| ovr_flag | output | 1 | Sticky overrun status |
| rx_irq | output | 1 | Receive interrupt request |
| fifo_full | output | 1 | Store full |
| fifo_empty | output | 1 | Store empty |

## Verification
`rd_data` is combinational, so the monitor compares it in the same cycle the read strobe is driven, just after the falling edge. `fifo_full`, `fifo_empty` and `ovr_flag` change at the rising edge that takes a strobe. The driver therefore checks them a moment after that edge, against a pointer-and-direction model that it updates from the values present before the edge. `rx_irq` follows `irq_en` combinationally and follows emptiness one edge after a strobe, and it is checked at both of those points.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             wr_acc,
    output logic             drop,
    output logic             full,
    output logic             empty
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    dir_e state, state_nx;
    logic ptrs_eq;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DIR_READ;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            DIR_READ:  if (wr_acc && !pop) state_nx = DIR_WRITE;
            DIR_WRITE: if (pop && !wr_acc) state_nx = DIR_READ;
            default:   state_nx = DIR_READ;
        endcase
    end

    // outputs
    always_comb begin
        ptrs_eq = (wr_ptr == rd_ptr);
        full    = ptrs_eq && (state == DIR_WRITE);
        empty   = ptrs_eq && (state == DIR_READ);
        wr_acc  = push && !full;
        drop    = push && full;
    end

    // pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_acc) wr_ptr <= bump(wr_ptr);
            if (pop)    rd_ptr <= bump(rd_ptr);
        end
    end
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int PTR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] din,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  slot[i] <= '0;
            else if (we && (wr_ptr == PTR_W'(i)))        slot[i] <= din;
        end
    end

    assign dout = slot[rd_ptr];
endmodule

// File: rtl/rxf_status.sv
module rxf_status (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr,
    input  logic empty,
    input  logic irq_en,
    output logic ovr_flag,
    output logic rx_irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ovr_flag <= 1'b0;
        else if (drop) ovr_flag <= 1'b1;
        else if (clr)  ovr_flag <= 1'b0;
    end

    assign rx_irq = irq_en && !empty;
endmodule

// File: rtl/rxf_audio_rx.sv
module rxf_audio_rx #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_en,
    input  logic              ovr_clr,
    output logic              ovr_flag,
    output logic              rx_irq,
    output logic              fifo_full,
    output logic              fifo_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             wr_acc, drop;

    rxf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(word_valid), .pop(rd_pop),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_acc(wr_acc), .drop(drop),
        .full(fifo_full), .empty(fifo_empty)
    );

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_acc), .wr_ptr(wr_ptr),
        .din(word_data), .rd_ptr(rd_ptr), .dout(rd_data)
    );

    rxf_status u_status (
        .clk(clk), .rst_n(rst_n), .drop(drop), .clr(ovr_clr),
        .empty(fifo_empty), .irq_en(irq_en),
        .ovr_flag(ovr_flag), .rx_irq(rx_irq)
    );
endmodule

// File: rtl/rxf_audio_rx_chk.sv
module rxf_audio_rx_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_valid,
    input logic [DATA_W-1:0] word_data,
    input logic              rd_pop,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_en,
    input logic              ovr_clr,
    input logic              ovr_flag,
    input logic              rx_irq,
    input logic              fifo_full,
    input logic              fifo_empty
);
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty)); // R3
    AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && fifo_full && !rd_pop) |=> fifo_full); // R4
    AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && fifo_full) |=> ovr_flag); // R5
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag); // R6
    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !rx_irq); // R7
    AST_DROP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && fifo_full && !rd_pop && $stable(irq_en)) |=> $stable(rx_irq)); // R8
    AST_POP_LEAVES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && rd_pop) |=> !fifo_full); // R2
    AST_PAIR_HOLDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && rd_pop && !fifo_full) |=> $stable(fifo_empty)); // R10
endmodule

bind rxf_audio_rx rxf_audio_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .rd_pop(rd_pop), .rd_data(rd_data), .irq_en(irq_en), .ovr_clr(ovr_clr),
    .ovr_flag(ovr_flag), .rx_irq(rx_irq), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty)
);

// File: tb/tb_rxf_audio_rx.sv
`timescale 1ns/1ps
module tb_rxf_audio_rx;
    localparam int DW = 16;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          word_valid = 1'b0;
    logic [DW-1:0] word_data = '0;
    logic          rd_pop = 1'b0;
    logic [DW-1:0] rd_data;
    logic          irq_en = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          ovr_flag, rx_irq, fifo_full, fifo_empty;

    int checks = 0;
    int errors = 0;

    // model
    logic [DW-1:0] mem_m [DP];
    int            wp = 0, rp = 0;
    bit            dir_w = 1'b0;
    bit            ovr_m = 1'b0;
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #2 clk = ~clk; // 250 MHz

    rxf_audio_rx #(.DATA_W(DW), .DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .rd_pop(rd_pop), .rd_data(rd_data), .irq_en(irq_en), .ovr_clr(ovr_clr),
        .ovr_flag(ovr_flag), .rx_irq(rx_irq), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty)
    );

    function automatic bit m_full();  return (wp == rp) && dir_w;  endfunction
    function automatic bit m_empty(); return (wp == rp) && !dir_w; endfunction

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk(req, "fifo_full",  DW'(fifo_full),  DW'(m_full()));
        chk(req, "fifo_empty", DW'(fifo_empty), DW'(m_empty()));
        chk(req, "ovr_flag",   DW'(ovr_flag),   DW'(ovr_m));
        chk(req, "rx_irq",     DW'(rx_irq),     DW'(irq_en && !m_empty()));
    endtask

    // driver: one clock of stimulus, model updated from pre-edge state
    task automatic cyc(input bit push, input logic [DW-1:0] d, input bit pop, input bit clr, input string tag);
        bit fb, acc;
        @(negedge clk);
        word_valid = push; word_data = d; rd_pop = pop; ovr_clr = clr;
        if (pop) begin
            exp_q.push_back(mem_m[rp]);
            tag_q.push_back(tag);
        end
        @(posedge clk);
        #1;
        word_valid = 1'b0; rd_pop = 1'b0; ovr_clr = 1'b0;
        fb  = m_full();
        acc = push && !fb;
        if (push && fb) ovr_m = 1'b1;
        else if (clr)   ovr_m = 1'b0;
        if (acc) begin mem_m[wp] = d; wp = (wp + 1) % DP; end
        if (pop) rp = (rp + 1) % DP;
        if (acc && !pop)      dir_w = 1'b1;
        else if (pop && !acc) dir_w = 1'b0;
    endtask

    // monitor: compare read data in the cycle the pop is driven
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_pop) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected read: actual %h expected none", rd_data);
                end else begin
                    chk(tag_q.pop_front(), "rd_data", rd_data, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DP; i++) mem_m[i] = '0;
        repeat (3) @(negedge clk);
        chk_flags("R11");
        rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R11");

        // R7: irq held low while disabled
        cyc(1, 16'hA001, 0, 0, "R1"); chk_flags("R7");
        @(negedge clk); irq_en = 1'b1; #1; chk_flags("R7");
        cyc(1, 16'hA002, 0, 0, "R1");
        cyc(1, 16'hA003, 0, 0, "R1");
        cyc(1, 16'hA004, 0, 0, "R1"); chk_flags("R3");
        // overrun
        cyc(1, 16'hBAD0, 0, 0, "R4"); chk_flags("R4"); chk_flags("R8");
        cyc(0, '0, 0, 0, "R6");       chk_flags("R6");
        for (int i = 0; i < DP; i++) cyc(0, '0, 1, 0, "R1");
        chk_flags("R3"); chk_flags("R6");
        cyc(0, '0, 0, 1, "R6");       chk_flags("R6");
        // simultaneous push/pop, wrap-around
        cyc(1, 16'hC001, 0, 0, "R10");
        cyc(1, 16'hC002, 0, 0, "R10");
        cyc(1, 16'hC003, 1, 0, "R10"); chk_flags("R10");
        cyc(0, '0, 1, 0, "R2");
        cyc(0, '0, 1, 0, "R2");        chk_flags("R3");
        // set wins over clear; pop with drop when full
        for (int i = 0; i < DP; i++) cyc(1, DW'(16'hD000 + i), 0, 0, "R1");
        cyc(1, 16'hBAD1, 0, 1, "R6");  chk_flags("R6");
        cyc(1, 16'hBAD2, 1, 0, "R4");  chk_flags("R4");
        cyc(0, '0, 1, 0, "R4");
        cyc(0, '0, 1, 0, "R4");
        cyc(0, '0, 1, 0, "R4");        chk_flags("R4");
        // underrun
        cyc(0, '0, 0, 1, "R6");        chk_flags("R6");
        cyc(0, '0, 1, 0, "R9");        chk_flags("R9");
        cyc(0, '0, 0, 0, "R9");        chk_flags("R9");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule